// File: doc/BRIEF.md
# Chip-Select Address Region Decoder

This block sits between a system interconnect and an external memory controller. It compares each incoming 32-bit access address against a set of independently programmed chip-select regions. For the region that claims the access, it produces a one-hot chip-select, the address offset inside that region, and the path that should carry the access. The possible paths are the plain memory path for NOR-style parts, the direct data path for NAND-style parts, and the prefetch FIFO port.

Each region holds four settings. There is a 6-bit base that lands on 16 MB boundaries and a 4-bit size mask over address bits 27:24. There is also an enable bit and a 2-bit device-type code. A simple write port loads these settings. The prefetch engine supplies an enable and the number of the region it owns. A strap input decides whether the 256 MB size is allowed. The result is registered and appears one clock after the access is presented.

Top module: `cs_region_decoder`

## Requirements
- R1: Reset state. Only region 0 is enabled, every mask is 0xF, every base is 0 and every type is NOR. Address 0x00ABCDEF therefore hits region 0 with offset 0xABCDEF, and 0x01000000 misses.
- R2: When `accValid` is high, the result appears on the outputs in the following cycle. In a cycle with no access presented the cycle before, `hit` and `noHit` are both low.
- R3: A region matches when all of the following hold:
  - address bits 31:30 are zero;
  - address bits 29:28 equal base bits 5:4;
  - address bits 27:24 equal base bits 3:0 in every position where the mask bit is 1.
- R4: Masks 0x8, 0xC, 0xE and 0xF give 128, 64, 32 and 16 MB regions. `offset` is address bits 27:0 with the mask-selected bits 27:24 cleared, so the device repeats every region-size bytes from the base.
- R5: Any mask other than 0x8, 0xC, 0xE and 0xF never matches. The one exception is mask 0x0 while `wideMaskOk` is high, which gives a 256 MB region.
- R6: A region whose enable bit is clear never matches.
- R7: When several enabled regions match, the lowest-numbered one wins and `csSel` has exactly that bit set.
- R8: A miss raises `noHit` and drives `csSel` = 0, `offset` = 0 and `target` = 0.
- R9: Target codes are NOR = 0, NAND = 1 and FIFO = 2. A device type of 2 routes to NAND. Types 0, 1 and 3 route to NOR.
- R10: A NAND-type hit routes to FIFO (2) only while `pfEnable` is high and `pfRegion` names that region. The prefetch inputs never change the routing of a NOR-type region.
- R11: When an access and a config write arrive in the same cycle, the access is decoded with the settings from before the write. The write applies from the next access on.
- R12: A config write with `cfgWe` high loads region `cfgRegion`, and `cfgWord` selects which word is written.
  - `cfgWord` = 0: the type is taken from `cfgData[11:10]`.
  - `cfgWord` = 1: the base is taken from bits 5:0, the enable from bit 6 and the mask from bits 11:8. Bit 7 is reserved and must be zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wideMaskOk | input | 1 | Strap that allows mask 0x0 (256 MB) |
| cfgWe | input | 1 | Config write strobe |
| cfgRegion | input | 3 | Region written |
| cfgWord | input | 1 | 0 = device-type word, 1 = map word |
| cfgData | input | 12 | Config write data |
| pfEnable | input | 1 | Prefetch engine enabled |
| pfRegion | input | 3 | Region owned by the prefetch engine |
| accValid | input | 1 | Access presented this cycle |
| accAddr | input | 32 | Access address |
| hit | output | 1 | Previous access matched a region |
| noHit | output | 1 | Previous access matched no region |
| csSel | output | 8 | One-hot chip-select |
| offset | output | 28 | Region-relative offset |
| target | output | 2 | Routing: 0 NOR, 1 NAND, 2 FIFO |

## Verification
The bench builds the block with its default of eight regions. This lets one regime hold, side by side, all four legal mask sizes, an illegal mask, a wide 256 MB region and two regions that overlap. Priority, aliasing and prefetch steering are then exercised in one run. A model in the bench keeps its own copy of every region's settings and predicts each result. A scoreboard compares those predictions, including the case where a write lands in the same cycle as an access.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int MAX_IDX_W = 4;

  typedef enum logic [1:0] {
    TGT_NOR  = 2'd0,
    TGT_NAND = 2'd1,
    TGT_FIFO = 2'd2
  } target_e;

  typedef struct packed {
    logic [5:0] base;
    logic [3:0] mask;
    logic       valid;
    logic [1:0] devType;
  } region_cfg_t;

  typedef struct packed {
    logic                 capture;
    logic                 devWr;
    logic                 mapWr;
    logic [MAX_IDX_W-1:0] region;
  } strobes_t;

endpackage

// File: rtl/csdec_ctrl.sv
module csdec_ctrl
  import csdec_pkg::*;
#(
  parameter int REGIONS = 8,
  localparam int IDX_W = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic             cfgWord,
  input  logic [IDX_W-1:0] cfgRegion,
  input  logic             accValid,
  output strobes_t         strb
);

  logic inRange;
  assign inRange = (32'(cfgRegion) < 32'(REGIONS));

  always_comb begin
    strb.capture = accValid;
    strb.devWr   = cfgWe && !cfgWord && inRange;
    strb.mapWr   = cfgWe && cfgWord && inRange;
    strb.region  = MAX_IDX_W'(cfgRegion);
  end

  // R12: one config word is written at a time
  a_r12_single_word: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.devWr, strb.mapWr}));

endmodule

// File: rtl/csdec_datapath.sv
module csdec_datapath
  import csdec_pkg::*;
#(
  parameter int REGIONS = 8,
  localparam int IDX_W = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int OFF_W = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wideMaskOk,
  input  strobes_t           strb,
  input  logic [11:0]        cfgData,
  input  logic               pfEnable,
  input  logic [IDX_W-1:0]   pfRegion,
  input  logic [31:0]        accAddr,
  output logic               hit,
  output logic               noHit,
  output logic [REGIONS-1:0] csSel,
  output logic [OFF_W-1:0]   offset,
  output logic [1:0]         target
);

  region_cfg_t  cfg    [REGIONS];
  target_e      regTgt [REGIONS];
  logic [REGIONS-1:0] match;

  for (genvar g = 0; g < REGIONS; g++) begin : gRegion
    logic legal;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[g].base    <= '0;
        cfg[g].mask    <= 4'hF;
        cfg[g].valid   <= 1'(g == 0);
        cfg[g].devType <= 2'd0;
      end else begin
        if (strb.devWr && strb.region == MAX_IDX_W'(g))
          cfg[g].devType <= cfgData[11:10];
        if (strb.mapWr && strb.region == MAX_IDX_W'(g)) begin
          cfg[g].base  <= cfgData[5:0];
          cfg[g].valid <= cfgData[6];
          cfg[g].mask  <= cfgData[11:8];
        end
      end
    end

    always_comb begin
      unique case (cfg[g].mask)
        4'h8, 4'hC, 4'hE, 4'hF: legal = 1'b1;
        4'h0:                   legal = wideMaskOk;
        default:                legal = 1'b0;
      endcase
      match[g] = cfg[g].valid && legal && (accAddr[31:30] == 2'b00) &&
                 (accAddr[29:28] == cfg[g].base[5:4]) &&
                 (((accAddr[27:24] ^ cfg[g].base[3:0]) & cfg[g].mask) == 4'h0);
      if (cfg[g].devType == 2'd2)
        regTgt[g] = (pfEnable && pfRegion == IDX_W'(g)) ? TGT_FIFO : TGT_NAND;
      else
        regTgt[g] = TGT_NOR;
    end
  end

  logic [REGIONS-1:0] pick;
  logic [3:0]         selMask;
  target_e            selTgt;
  logic               found;

  always_comb begin
    pick    = '0;
    selMask = 4'h0;
    selTgt  = TGT_NOR;
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        selMask = cfg[i].mask;
        selTgt  = regTgt[i];
      end
    end
    found = |match;
  end

  target_e tgtQ;

  always_ff @(posedge clk) begin
    if (rst || !strb.capture) begin
      hit    <= 1'b0;
      noHit  <= 1'b0;
      csSel  <= '0;
      offset <= '0;
      tgtQ   <= TGT_NOR;
    end else begin
      hit    <= found;
      noHit  <= !found;
      csSel  <= pick;
      offset <= found ? {accAddr[27:24] & ~selMask, accAddr[23:0]} : '0;
      tgtQ   <= found ? selTgt : TGT_NOR;
    end
  end

  assign target = tgtQ;

  // R2: no result without an access the cycle before
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> (!hit && !noHit));

  // R7: at most one chip-select
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(csSel));

  // R8: a miss carries no select, no offset, NOR target
  a_r8_miss_clean: assert property (@(posedge clk) disable iff (rst)
    noHit |-> (!hit && csSel == '0 && offset == '0 && target == 2'd0));

  // R7: a hit always names exactly one region
  a_r7_hit_select: assert property (@(posedge clk) disable iff (rst)
    hit |-> $countones(csSel) == 1);

  // R10: FIFO routing requires the prefetch engine enabled
  a_r10_fifo_needs_pf: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && !pfEnable) |=> (target != 2'd2));

  // R12: reserved map bit is written as zero
  a_r12_reserved_bit: assert property (@(posedge clk) disable iff (rst)
    strb.mapWr |-> !cfgData[7]);

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
  import csdec_pkg::*;
#(
  parameter int REGIONS = 8,
  localparam int IDX_W = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int OFF_W = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wideMaskOk,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgRegion,
  input  logic               cfgWord,
  input  logic [11:0]        cfgData,
  input  logic               pfEnable,
  input  logic [IDX_W-1:0]   pfRegion,
  input  logic               accValid,
  input  logic [31:0]        accAddr,
  output logic               hit,
  output logic               noHit,
  output logic [REGIONS-1:0] csSel,
  output logic [OFF_W-1:0]   offset,
  output logic [1:0]         target
);

  strobes_t strb;

  csdec_ctrl #(.REGIONS(REGIONS)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .cfgWe     (cfgWe),
    .cfgWord   (cfgWord),
    .cfgRegion (cfgRegion),
    .accValid  (accValid),
    .strb      (strb)
  );

  csdec_datapath #(.REGIONS(REGIONS)) uData (
    .clk        (clk),
    .rst        (rst),
    .wideMaskOk (wideMaskOk),
    .strb       (strb),
    .cfgData    (cfgData),
    .pfEnable   (pfEnable),
    .pfRegion   (pfRegion),
    .accAddr    (accAddr),
    .hit        (hit),
    .noHit      (noHit),
    .csSel      (csSel),
    .offset     (offset),
    .target     (target)
  );

endmodule

// File: tb/cs_region_decoder_test.sv
module cs_region_decoder_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        hit;
    logic [7:0]  cs;
    logic [27:0] off;
    logic [1:0]  tgt;
  } result_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wideMaskOk = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgRegion = '0;
  logic        cfgWord = 1'b0;
  logic [11:0] cfgData = '0;
  logic        pfEnable = 1'b0;
  logic [2:0]  pfRegion = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        hit, noHit;
  logic [7:0]  csSel;
  logic [27:0] offset;
  logic [1:0]  target;

  cs_region_decoder uut (
    .clk(clk), .rst(rst), .wideMaskOk(wideMaskOk), .cfgWe(cfgWe),
    .cfgRegion(cfgRegion), .cfgWord(cfgWord), .cfgData(cfgData),
    .pfEnable(pfEnable), .pfRegion(pfRegion), .accValid(accValid),
    .accAddr(accAddr), .hit(hit), .noHit(noHit), .csSel(csSel),
    .offset(offset), .target(target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // shadow configuration kept by the bench
  logic [5:0] mBase  [8];
  logic [3:0] mMask  [8];
  logic       mValid [8];
  logic [1:0] mType  [8];

  result_t expQ[$];
  string   tagQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic result_t model(input logic [31:0] a);
    result_t r;
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      bit legal;
      legal = (mMask[i] == 4'h8 || mMask[i] == 4'hC || mMask[i] == 4'hE ||
               mMask[i] == 4'hF || (mMask[i] == 4'h0 && wideMaskOk));
      if (mValid[i] && legal && a[31:30] == 2'b00 && a[29:28] == mBase[i][5:4] &&
          ((a[27:24] ^ mBase[i][3:0]) & mMask[i]) == 4'h0) begin
        r.hit = 1'b1;
        r.cs  = 8'(1) << i;
        r.off = {a[27:24] & ~mMask[i], a[23:0]};
        if (mType[i] == 2'd2)
          r.tgt = (pfEnable && pfRegion == 3'(i)) ? 2'd2 : 2'd1;
        else
          r.tgt = 2'd0;
      end
    end
    return r;
  endfunction

  task automatic shadowWrite(input int r, input bit word, input logic [11:0] d);
    if (word) begin
      mBase[r] = d[5:0]; mValid[r] = d[6]; mMask[r] = d[11:8];
    end else begin
      mType[r] = d[11:10];
    end
  endtask

  task automatic cfgWrite(input int r, input bit word, input logic [11:0] d);
    cfgWe = 1'b1; cfgRegion = 3'(r); cfgWord = word; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    shadowWrite(r, word, d);
  endtask

  task automatic access(input logic [31:0] a, input string tag);
    accValid = 1'b1; accAddr = a;
    expQ.push_back(model(a)); tagQ.push_back(tag);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  // R11: access and config write in the same cycle
  task automatic accessWithWrite(input logic [31:0] a, input string tag,
                                 input int r, input bit word, input logic [11:0] d);
    accValid = 1'b1; accAddr = a;
    cfgWe = 1'b1; cfgRegion = 3'(r); cfgWord = word; cfgData = d;
    expQ.push_back(model(a)); tagQ.push_back(tag);
    @(negedge clk);
    accValid = 1'b0; cfgWe = 1'b0;
    shadowWrite(r, word, d);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check(!hit && !noHit, "R2", "idle hit/noHit", {hit, noHit}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && (hit || noHit)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected result", {hit, noHit}, 0);
      end else begin
        result_t e;
        string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        check(hit == e.hit && noHit == !e.hit, t, "hit", hit, e.hit);
        check(csSel == e.cs, t, "csSel", csSel, e.cs);
        check(offset == e.off, t, "offset", offset, e.off);
        check(target == e.tgt, t, "target", target, e.tgt);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0; mMask[i] = 4'hF; mValid[i] = (i == 0); mType[i] = 2'd0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!hit && !noHit && csSel == 0 && offset == 0, "R1", "reset outputs",
          {hit, noHit, csSel}, 0);

    access(32'h00ABCDEF, "R1");
    access(32'h01000000, "R1");
    access(32'hC0000000, "R3");
    idleCheck();

    // R12 / R3: region 1 at 0x12, 16 MB
    cfgWrite(1, 1'b1, 12'hF52);
    access(32'h12345678, "R12");
    access(32'h22345678, "R3");

    // R4: mask sizes and aliasing
    cfgWrite(2, 1'b1, 12'hC44);
    access(32'h07123456, "R4");
    access(32'h05000000, "R4");
    cfgWrite(3, 1'b1, 12'h848);
    access(32'h0FFFFFFF, "R4");
    cfgWrite(4, 1'b1, 12'hE50);
    access(32'h11000010, "R4");

    // R5: illegal and wide masks
    cfgWrite(5, 1'b1, 12'h360);
    access(32'h20000000, "R5");
    cfgWrite(5, 1'b1, 12'h060);
    access(32'h20000000, "R5");
    @(negedge clk);
    wideMaskOk = 1'b1;
    access(32'h20000000, "R5");
    access(32'h2ABCDEF0, "R5");

    // R6: disabled region
    cfgWrite(1, 1'b1, 12'hF12);
    access(32'h12345678, "R6");

    // R7: priority
    cfgWrite(6, 1'b1, 12'hF52);
    access(32'h12000000, "R7");
    cfgWrite(1, 1'b1, 12'hF52);
    access(32'h12000000, "R7");

    // R9: device type routing on region 1
    cfgWrite(1, 1'b0, 12'h800);
    access(32'h12000040, "R9");
    cfgWrite(1, 1'b0, 12'hC00);
    access(32'h12000040, "R9");
    cfgWrite(1, 1'b0, 12'h800);

    // R10: prefetch steering
    pfEnable = 1'b1; pfRegion = 3'd1;
    access(32'h12000080, "R10");
    pfRegion = 3'd5;
    access(32'h12000080, "R10");
    access(32'h20000000, "R10");
    pfEnable = 1'b0; pfRegion = 3'd1;
    access(32'h12000080, "R10");

    // R11: write in the same cycle as an access
    accessWithWrite(32'h12000000, "R11", 1, 1'b1, 12'hF12);
    access(32'h12000000, "R11");
    idleCheck();

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "pending results", 64'(expQ.size()), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule